// File: doc/BRIEF.md
# UART Prioritized Interrupt Identifier

This block decides which interrupt a 16550-style UART reports to its host. It takes four enable bits written by software and the live interrupt sources of the serial channel: a receiver error event, received data available (or FIFO trigger reached), character timeout, transmit holding register empty, and modem control line changes. It reports the single most urgent pending source as a 4-bit identification code, with a FIFO-mode flag in the top bit of the identification byte.

The block also keeps the modem status byte. The four active-low modem inputs (clear to send, data set ready, ring indicator, carrier detect) pass through two synchronizing flops. Change detectors then raise sticky delta bits. The interrupt request pin is qualified by the OUT2 control bit, so software can mask the whole channel at the pin.

Each source has its own clear event: a read of the line status register, a read of the modem status register, a holding register write, or a read of the identification byte itself. The surrounding UART delivers these as one-cycle strobes. The priority is resolved again in every cycle.

Top module: `uart_irq_ident`

## Requirements
- R1: With no enabled source pending, `iir[3:0]` is 0001. Whenever a source is pending, `iir[0]` is 0.
- R2: Priority and codes, highest first: line error 0110; received data 0100; character timeout 1100 (same tier as received data, but data wins when both are present); holding empty 0010; modem status 0000.
- R3: The enable byte is written by `ier_wr` with `ier_wdata`. Bit 0 gates received data and timeout, bit 1 gates holding empty, bit 2 gates line error, and bit 3 gates modem status. `ier_q` returns bits 3:0 as written and bits 7:4 as zero.
- R4: A `line_err` pulse sets a sticky line error source, and `lsr_rd` clears it. When both occur in the same cycle, the source stays set.
- R5: The holding-empty source is set in either of two cases: `thr_empty` rises, or enable bit 1 is written from 0 to 1 while `thr_empty` is 1. It is cleared by `thr_wr`, or by `iir_rd` in a cycle where `iir[3:0]` is 0010. A read of the identification byte while another code is shown leaves it pending.
- R6: When `fifo_mode` is 0, the timeout source is ignored and `iir[3]` is 0. `iir[7]` equals `fifo_mode`, and `iir[6:4]` is 0.
- R7: The modem status byte holds the complements of the synchronized inputs: bit 4 for `cts_n`, bit 5 for `dsr_n`, bit 6 for `ri_n`, and bit 7 for `dcd_n`. A pin change appears two clock edges later.
- R8: Delta bits are set as follows: bit 0 on any change of clear to send, bit 1 on any change of data set ready, and bit 3 on any change of carrier detect. Bit 2 is set only when `ri_n` goes from 0 to 1. `msr_rd` clears all four delta bits, but a delta detected in the same cycle is kept. Any delta bit that is set is a modem status source.
- R9: `irq` is high exactly when `out2` is 1 and a source is pending.
- R10: The priority is re-evaluated every cycle. A higher source that becomes pending replaces the reported code in the same cycle its state is visible, and the lower code returns when it clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_wr | input | 1 | Enable byte write strobe |
| ier_wdata | input | 8 | Enable byte write data |
| ier_q | output | 8 | Enable byte read value |
| fifo_mode | input | 1 | FIFO mode enabled |
| line_err | input | 1 | Receiver error event pulse |
| lsr_rd | input | 1 | Line status read strobe |
| rx_avail | input | 1 | Received data present or trigger level reached |
| rx_timeout | input | 1 | Character timeout condition |
| thr_empty | input | 1 | Transmit holding register empty |
| thr_wr | input | 1 | Holding register write strobe |
| iir_rd | input | 1 | Identification byte read strobe |
| cts_n | input | 1 | Clear to send, active low |
| dsr_n | input | 1 | Data set ready, active low |
| ri_n | input | 1 | Ring indicator, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| msr_rd | input | 1 | Modem status read strobe |
| out2 | input | 1 | Interrupt pin enable control |
| iir | output | 8 | Identification byte |
| msr | output | 8 | Modem status byte |
| irq | output | 1 | Interrupt request |

## Verification
A vector table sweeps combinations of enable bits, FIFO mode, data, timeout and error events. It separates the priority order from the enable gating and from the character-mode suppression of the timeout code. Directed sequences cover each holding-empty set and clear path, including a read of the identification byte while a higher code is shown. The modem tests toggle each input separately, so each line's delta position can be identified. They also separate the ring trailing edge from the leading edge and confirm that a delta arriving in the same cycle as a status read survives that read. Same-cycle error set and status read, pre-emption and return of a lower code, and the OUT2 gating of the pin are checked explicitly.

// File: rtl/uart_irq_ident.sv
module uart_irq_ident (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ier_wr,
  input  logic [7:0] ier_wdata,
  output logic [7:0] ier_q,
  input  logic       fifo_mode,
  input  logic       line_err,
  input  logic       lsr_rd,
  input  logic       rx_avail,
  input  logic       rx_timeout,
  input  logic       thr_empty,
  input  logic       thr_wr,
  input  logic       iir_rd,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       dcd_n,
  input  logic       msr_rd,
  input  logic       out2,
  output logic [7:0] iir,
  output logic [7:0] msr,
  output logic       irq
);

  logic [3:0] en;
  logic       ls_flag;
  logic       thre_flag;
  logic       thr_empty_d;
  logic [3:0] pin_s1, pin_s2, pin_s3;
  logic [3:0] delta;
  logic [3:0] delta_hit;
  logic [3:0] code;
  logic       src_ls, src_rd, src_to, src_th, src_ms;
  logic       thre_set, thre_clr;

  // pin vector order: 3 carrier, 2 ring, 1 set ready, 0 clear to send
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_s1 <= 4'hF;
      pin_s2 <= 4'hF;
      pin_s3 <= 4'hF;
    end else begin
      pin_s1 <= {dcd_n, ri_n, dsr_n, cts_n};
      pin_s2 <= pin_s1;
      pin_s3 <= pin_s2;
    end
  end

  assign delta_hit = {pin_s2[3] ^ pin_s3[3],
                      pin_s2[2] & ~pin_s3[2],
                      pin_s2[1] ^ pin_s3[1],
                      pin_s2[0] ^ pin_s3[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) delta <= 4'h0;
    else        delta <= (msr_rd ? 4'h0 : delta) | delta_hit;
  end

  assign msr = {~pin_s2, delta};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en <= 4'h0;
    else if (ier_wr) en <= ier_wdata[3:0];
  end

  assign ier_q = {4'h0, en};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ls_flag <= 1'b0;
    else if (line_err) ls_flag <= 1'b1;
    else if (lsr_rd)  ls_flag <= 1'b0;
  end

  assign thre_set = (thr_empty & ~thr_empty_d) |
                    (ier_wr & ier_wdata[1] & ~en[1] & thr_empty);
  assign thre_clr = thr_wr | (iir_rd & (code == 4'b0010));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_empty_d <= 1'b1;
      thre_flag   <= 1'b0;
    end else begin
      thr_empty_d <= thr_empty;
      if (thre_set)      thre_flag <= 1'b1;
      else if (thre_clr) thre_flag <= 1'b0;
    end
  end

  assign src_ls = en[2] & ls_flag;
  assign src_rd = en[0] & rx_avail;
  assign src_to = en[0] & fifo_mode & rx_timeout;
  assign src_th = en[1] & thre_flag;
  assign src_ms = en[3] & (|delta);

  always_comb begin
    if (src_ls)      code = 4'b0110;
    else if (src_rd) code = 4'b0100;
    else if (src_to) code = 4'b1100;
    else if (src_th) code = 4'b0010;
    else if (src_ms) code = 4'b0000;
    else             code = 4'b0001;
  end

  assign iir = {fifo_mode, 3'b000, code};
  assign irq = out2 & ~code[0];

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ier_wr,
  input logic [7:0] ier_q,
  input logic       fifo_mode,
  input logic       line_err,
  input logic       thr_empty,
  input logic       thr_wr,
  input logic       iir_rd,
  input logic       out2,
  input logic [7:0] iir,
  input logic       irq
);

  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (out2 && !irq) |-> (iir[3:0] == 4'b0001)); // R1

  AST_LS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (line_err && ier_q[2] && !ier_wr) |=> (iir[3:0] == 4'b0110)); // R2

  AST_THRE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && iir[3:0] == 4'b0010 && thr_empty && $past(thr_empty) && !ier_wr)
      |=> (iir[3:0] != 4'b0010)); // R5

  AST_CHAR_BIT3: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |-> !iir[3]); // R6

  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !out2 |-> !irq); // R9

  AST_WR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && thr_empty && $past(thr_empty) && !ier_wr && iir[3:0] == 4'b0010)
      |=> (iir[3:0] != 4'b0010)); // R5

endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_q(ier_q),
  .fifo_mode(fifo_mode), .line_err(line_err), .thr_empty(thr_empty),
  .thr_wr(thr_wr), .iir_rd(iir_rd), .out2(out2), .iir(iir), .irq(irq)
);

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ier_wr = 0;
  logic [7:0] ier_wdata = 0;
  logic [7:0] ier_q;
  logic       fifo_mode = 0, line_err = 0, lsr_rd = 0, rx_avail = 0, rx_timeout = 0;
  logic       thr_empty = 1, thr_wr = 0, iir_rd = 0;
  logic       cts_n = 1, dsr_n = 1, ri_n = 1, dcd_n = 1, msr_rd = 0, out2 = 0;
  logic [7:0] iir, msr;
  logic       irq;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  uart_irq_ident i_uart_irq_ident (.*);

  // fields: [11:8] enable, [7] fifo, [6] data, [5] timeout, [4] error, [3:0] code
  localparam logic [11:0] VEC [0:8] = '{
    12'b0000_0_0_0_0_0001,
    12'b0001_0_1_0_0_0100,
    12'b0001_0_0_1_0_0001,
    12'b0001_1_0_1_0_1100,
    12'b0101_1_1_1_1_0110,
    12'b0001_1_1_1_0_0100,
    12'b0100_0_1_0_1_0110,
    12'b0000_0_1_0_1_0001,
    12'b1101_1_0_1_0_1100
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr_ier(input logic [7:0] v);
    ier_wr = 1; ier_wdata = v; tick(1); ier_wr = 0;
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(2);
    chk("R1 reset iir", iir, 8'h01);
    chk("R3 reset ier", ier_q, 8'h00);
    chk("R7 reset msr", msr, 8'h00);
    chk("R9 reset irq", {7'd0, irq}, 8'h00);
    rst_n = 1;
    tick(2);

    for (int v = 0; v < 9; v++) begin
      ier_wr = 1; ier_wdata = {4'h0, VEC[v][11:8]};
      fifo_mode = VEC[v][7]; rx_avail = VEC[v][6]; rx_timeout = VEC[v][5];
      line_err = VEC[v][4];
      tick(1);
      ier_wr = 0; line_err = 0;
      chk($sformatf("R2 R3 R6 vector %0d", v), iir, {VEC[v][7], 3'b000, VEC[v][3:0]});
      lsr_rd = 1; rx_avail = 0; rx_timeout = 0; tick(1); lsr_rd = 0;
    end
    fifo_mode = 0;

    wr_ier(8'hF4);
    chk("R3 upper ier zero", ier_q, 8'h04);
    line_err = 1; lsr_rd = 1; tick(1); line_err = 0; lsr_rd = 0;
    chk("R4 error kept over same cycle read", iir, 8'h06);
    lsr_rd = 1; tick(1); lsr_rd = 0;
    chk("R4 error cleared by read", iir, 8'h01);

    wr_ier(8'h02);
    chk("R5 enable rise while empty", iir, 8'h02);
    chk("R9 irq masked by out2", {7'd0, irq}, 8'h00);
    out2 = 1; tick(1);
    chk("R9 irq with out2", {7'd0, irq}, 8'h01);
    iir_rd = 1; tick(1); iir_rd = 0;
    chk("R5 cleared by id read", iir, 8'h01);
    chk("R1 irq low when idle", {7'd0, irq}, 8'h00);
    thr_empty = 0; tick(1); thr_empty = 1; tick(1);
    chk("R5 set on empty rise", iir, 8'h02);
    thr_wr = 1; thr_empty = 0; tick(1); thr_wr = 0; thr_empty = 1; tick(1);
    chk("R5 set again after write and refill", iir, 8'h02);
    thr_wr = 1; tick(1); thr_wr = 0;
    chk("R5 cleared by holding write", iir, 8'h01);

    thr_empty = 0; wr_ier(8'h07); thr_empty = 1; tick(1);
    chk("R10 base holding code", iir, 8'h02);
    rx_avail = 1; #1;
    chk("R10 data preempts at once", iir, 8'h04);
    line_err = 1; tick(1); line_err = 0;
    chk("R10 error preempts", iir, 8'h06);
    iir_rd = 1; tick(1); iir_rd = 0;
    lsr_rd = 1; rx_avail = 0; tick(1); lsr_rd = 0;
    chk("R5 id read under other code keeps holding", iir, 8'h02);
    thr_wr = 1; tick(1); thr_wr = 0;

    wr_ier(8'h08);
    cts_n = 0; tick(1);
    chk("R7 not yet visible after one edge", msr, 8'h00);
    tick(3);
    chk("R7 R8 cts active and delta", msr, 8'h11);
    chk("R8 modem code", iir, 8'h00);
    msr_rd = 1; tick(1); msr_rd = 0;
    chk("R8 delta cleared", msr, 8'h10);
    chk("R1 idle after modem read", iir, 8'h01);
    ri_n = 0; tick(4);
    chk("R8 ring leading edge no delta", msr, 8'h50);
    ri_n = 1; tick(4);
    chk("R8 ring trailing edge", msr, 8'h14);
    msr_rd = 1; tick(1); msr_rd = 0;
    dsr_n = 0; tick(4);
    chk("R7 R8 set ready", msr, 8'h32);
    msr_rd = 1; tick(1); msr_rd = 0;
    dcd_n = 0; tick(4);
    chk("R7 R8 carrier", msr, 8'hB8);
    msr_rd = 1; tick(1); msr_rd = 0;
    cts_n = 1; tick(2);
    msr_rd = 1; tick(1); msr_rd = 0;
    chk("R8 delta kept over same cycle read", msr, 8'hA1);
    out2 = 0; tick(1);
    chk("R9 masked with modem pending", {7'd0, irq}, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule